// File: doc/BRIEF.md
# Byte/Word Rotate and Shift Unit

This is a purely combinational datapath slice for a 16-bit x86-family execution core. It takes one operand, a shift count, an operation code and a width select. In the same cycle it returns the rotated or shifted value and the new carry. For the shift operations it also returns new sign, zero and parity flags. Operand fetch, result write-back and the overflow flag belong to the surrounding core and are not part of this unit.

Seven operations are supported:

- plain rotates left and right;
- rotates through carry left and right;
- shift left;
- logical shift right;
- arithmetic shift right.

A narrow (byte) mode works on the low half of the operand. A wide (word) mode works on the full operand. In every operation the carry output is the last bit that left the value. The rotate-through-carry forms treat the carry as one more bit of a ring that is 9 or 17 bits long.

The incoming carry, sign, zero and parity flags are inputs. Outputs that an operation does not change simply repeat them. The core can therefore write all four flags back without knowing which operation ran.

Top module: `shift_rotate_unit`

## Requirements
- R1: `op_sel` encodings: 0 rotate left, 1 rotate right, 2 rotate left through carry, 3 rotate right through carry, 4 shift left, 5 logical shift right, 7 arithmetic shift right, 6 reserved. `wide_sel`=1 selects the 16-bit operand and `wide_sel`=0 selects the low 8 bits.
- R2: Rotate left by c repeats c single steps. Each step moves the top bit of the selected width into bit 0 and into the carry. For c ≥ 1, `carry_out` equals bit 0 of the result.
- R3: Rotate right by c repeats c single steps. Each step moves bit 0 into the top bit of the selected width and into the carry.
- R4: Rotate left through carry repeats c steps. Each step puts the old carry into bit 0 and the old top bit into the carry. A count that is a multiple of width+1 returns the operand and the carry unchanged.
- R5: Rotate right through carry repeats c steps. Each step puts the old carry into the top bit and the old bit 0 into the carry.
- R6: Shift left by c fills with zeros. The carry is the last bit shifted out of the top of the selected width.
- R7: Logical shift right by c fills with zeros. The carry is bit c-1 of the operand.
- R8: Arithmetic shift right by c fills with copies of the sign bit. For c within the width, the carry is bit c-1 of the operand.
- R9: After a shift with count ≥ 1, the output flags are set from the result:
  - `sign_out` is the result's top bit in the selected width;
  - `zero_out` is 1 when the result is zero;
  - `parity_out` is 1 when the low 8 result bits hold an even number of ones.
- R10: After a rotate, `sign_out`, `zero_out` and `parity_out` equal `sign_in`, `zero_in` and `parity_in`.
- R11: With count 0, or with `op_sel`=6, the result equals the operand within the selected width, and all four flag outputs equal their inputs.
- R12: For counts at or above the width:
  - shift left and logical shift right give 0;
  - arithmetic shift right gives all copies of the sign bit;
  - the carry is 0 for the zero-fill shifts whenever the count exceeds the width, and is the sign bit for arithmetic shift right.
- R13: In narrow mode, result bits 15..8 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 16 | Value to rotate or shift |
| count | input | 5 | Number of bit positions, 0 to 31 |
| op_sel | input | 3 | Operation code (see R1) |
| wide_sel | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| carry_in | input | 1 | Incoming carry flag |
| sign_in | input | 1 | Incoming sign flag |
| zero_in | input | 1 | Incoming zero flag |
| parity_in | input | 1 | Incoming parity flag |
| result | output | 16 | Rotated or shifted value |
| carry_out | output | 1 | New carry flag |
| sign_out | output | 1 | New sign flag |
| zero_out | output | 1 | New zero flag |
| parity_out | output | 1 | New parity flag |

## Verification
The hardest case to reach from the ports is a rotate through carry whose count is an exact multiple of the ring length (9 in byte mode, 17 in word mode). There the ring wraps fully and both the value and the carry must return untouched. Uniform random counts land on those few values only rarely, so directed vectors use counts 9 and 17 with a set carry. The same gap exists for shifts whose count sits exactly on the width or one past it, where the carry changes from the last real bit to zero or sign. Directed vectors cover counts 16, 17 and 20 on both sides of that boundary. Several thousand random vectors across all op codes and both widths then fill in the rest.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

    typedef enum logic [2:0] {
        OP_ROL = 3'd0,
        OP_ROR = 3'd1,
        OP_RCL = 3'd2,
        OP_RCR = 3'd3,
        OP_SHL = 3'd4,
        OP_SHR = 3'd5,
        OP_RSV = 3'd6,
        OP_SAR = 3'd7
    } rsu_op_e;

    typedef struct packed {
        logic carry;
        logic sign;
        logic zero;
        logic parity;
    } rsu_flags_t;

    localparam int PARITY_W = 8;

    // 1 when the byte holds an even number of ones
    function automatic logic even_parity(input logic [PARITY_W-1:0] b);
        return ~^b;
    endfunction

    function automatic logic op_is_rotate(input rsu_op_e o);
        return (o == OP_ROL) || (o == OP_ROR) || (o == OP_RCL) || (o == OP_RCR);
    endfunction

    function automatic logic op_is_shift(input rsu_op_e o);
        return (o == OP_SHL) || (o == OP_SHR) || (o == OP_SAR);
    endfunction

endpackage

// File: rtl/rsu_rotator.sv
module rsu_rotator #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic [DATA_W-1:0] opd_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              wide_i,
    input  logic              carry_i,
    input  logic              thru_i,
    input  logic              left_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o
);
    localparam int HALF_W    = DATA_W / 2;
    localparam int MAX_STEPS = (1 << CNT_W) - 1;

    logic [DATA_W-1:0] v, nv;
    logic              c, top, b0, ins;

    // One single-bit step per count value, each stage enabled while s < count
    always_comb begin
        v   = opd_i;
        c   = carry_i;
        nv  = '0;
        top = 1'b0;
        b0  = 1'b0;
        ins = 1'b0;
        for (int s = 0; s < MAX_STEPS; s++) begin
            if (CNT_W'(s) < cnt_i) begin
                if (left_i) begin
                    top = wide_i ? v[DATA_W-1] : v[HALF_W-1];
                    ins = thru_i ? c : top;
                    nv  = v << 1;
                    if (!wide_i) nv[DATA_W-1:HALF_W] = '0;
                    nv[0] = ins;
                    c   = top;
                end else begin
                    b0  = v[0];
                    ins = thru_i ? c : b0;
                    nv  = v >> 1;
                    if (wide_i) nv[DATA_W-1] = ins;
                    else        nv[HALF_W-1] = ins;
                    c   = b0;
                end
                v = nv;
            end
        end
        res_o   = v;
        carry_o = c;
    end

endmodule

// File: rtl/rsu_shifter.sv
module rsu_shifter
    import rsu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic [DATA_W-1:0] opd_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              wide_i,
    input  rsu_op_e           op_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int EXT_W  = DATA_W + (1 << CNT_W);

    logic [EXT_W-1:0]  ext_z, ext_s, left_v, right_v, arith_v;
    logic [DATA_W-1:0] width_mask;
    logic [CNT_W-1:0]  cnt_m1;
    logic              sgn;

    always_comb begin
        width_mask = wide_i ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        sgn        = wide_i ? opd_i[DATA_W-1] : opd_i[HALF_W-1];
        ext_z      = EXT_W'(opd_i);
        ext_s      = ext_z | ({EXT_W{sgn}} << (wide_i ? DATA_W : HALF_W));
        cnt_m1     = cnt_i - CNT_W'(1);
        // shift by count-1 so bit 0 holds the last bit to leave on the right
        left_v     = ext_z << cnt_i;
        right_v    = ext_z >> cnt_m1;
        arith_v    = EXT_W'($signed(ext_s) >>> cnt_m1);

        case (op_i)
            OP_SHL: begin
                res_o   = left_v[DATA_W-1:0] & width_mask;
                carry_o = wide_i ? left_v[DATA_W] : left_v[HALF_W];
            end
            OP_SHR: begin
                res_o   = right_v[DATA_W:1] & width_mask;
                carry_o = right_v[0];
            end
            OP_SAR: begin
                res_o   = arith_v[DATA_W:1] & width_mask;
                carry_o = arith_v[0];
            end
            default: begin
                res_o   = opd_i;
                carry_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rsu_flag_gen.sv
module rsu_flag_gen
    import rsu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic              wide_i,
    output logic              sign_o,
    output logic              zero_o,
    output logic              parity_o
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        sign_o   = wide_i ? res_i[DATA_W-1] : res_i[HALF_W-1];
        zero_o   = (res_i == '0);
        parity_o = even_parity(res_i[PARITY_W-1:0]);
    end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import rsu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  count,
    input  logic [2:0]        op_sel,
    input  logic              wide_sel,
    input  logic              carry_in,
    input  logic              sign_in,
    input  logic              zero_in,
    input  logic              parity_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              sign_out,
    output logic              zero_out,
    output logic              parity_out
);
    localparam int HALF_W = DATA_W / 2;

    rsu_op_e           op;
    logic [DATA_W-1:0] opd_m, rot_res, sh_res;
    logic              rot_c, sh_c, fl_s, fl_z, fl_p;
    rsu_flags_t        fl_out;

    assign op    = rsu_op_e'(op_sel);
    assign opd_m = wide_sel ? operand : {{HALF_W{1'b0}}, operand[HALF_W-1:0]};

    rsu_rotator #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_rot (
        .opd_i   (opd_m),
        .cnt_i   (count),
        .wide_i  (wide_sel),
        .carry_i (carry_in),
        .thru_i  ((op == OP_RCL) || (op == OP_RCR)),
        .left_i  ((op == OP_ROL) || (op == OP_RCL)),
        .res_o   (rot_res),
        .carry_o (rot_c)
    );

    rsu_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_shf (
        .opd_i   (opd_m),
        .cnt_i   (count),
        .wide_i  (wide_sel),
        .op_i    (op),
        .res_o   (sh_res),
        .carry_o (sh_c)
    );

    rsu_flag_gen #(.DATA_W(DATA_W)) i_flg (
        .res_i    (sh_res),
        .wide_i   (wide_sel),
        .sign_o   (fl_s),
        .zero_o   (fl_z),
        .parity_o (fl_p)
    );

    always_comb begin
        result = opd_m;
        fl_out = '{carry: carry_in, sign: sign_in, zero: zero_in, parity: parity_in};
        if (count != '0) begin
            if (op_is_rotate(op)) begin
                result       = rot_res;
                fl_out.carry = rot_c;
            end else if (op_is_shift(op)) begin
                result = sh_res;
                fl_out = '{carry: sh_c, sign: fl_s, zero: fl_z, parity: fl_p};
            end
        end
    end

    assign carry_out  = fl_out.carry;
    assign sign_out   = fl_out.sign;
    assign zero_out   = fl_out.zero;
    assign parity_out = fl_out.parity;

endmodule

// File: rtl/rsu_checker.sv
module rsu_checker #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input logic [DATA_W-1:0] operand,
    input logic [CNT_W-1:0]  count,
    input logic [2:0]        op_sel,
    input logic              wide_sel,
    input logic              carry_in,
    input logic              sign_in,
    input logic              zero_in,
    input logic              parity_in,
    input logic [DATA_W-1:0] result,
    input logic              carry_out,
    input logic              sign_out,
    input logic              zero_out,
    input logic              parity_out
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] msk;
    logic [CNT_W-1:0]  wid;
    logic              known, sgn;

    always_comb begin
        msk   = wide_sel ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        wid   = wide_sel ? CNT_W'(DATA_W) : CNT_W'(HALF_W);
        sgn   = wide_sel ? operand[DATA_W-1] : operand[HALF_W-1];
        known = !$isunknown({operand, count, op_sel, wide_sel, carry_in, sign_in,
                             zero_in, parity_in, result, carry_out, sign_out,
                             zero_out, parity_out});
        if (known) begin
            p_count_zero_pass_r11: assert (count != '0 ||
                (result == (operand & msk) && carry_out == carry_in &&
                 sign_out == sign_in && zero_out == zero_in && parity_out == parity_in))
                else $error("count zero changed state");
            p_rotate_keeps_szp_r10: assert (op_sel > 3'd3 ||
                (sign_out == sign_in && zero_out == zero_in && parity_out == parity_in))
                else $error("rotate touched sign/zero/parity");
            p_narrow_upper_clear_r13: assert (wide_sel || result[DATA_W-1:HALF_W] == '0)
                else $error("narrow result upper half not clear");
            p_rol_carry_r2: assert (op_sel != 3'd0 || count == '0 || carry_out == result[0])
                else $error("rotate left carry mismatch");
            p_ror_carry_r3: assert (op_sel != 3'd1 || count == '0 ||
                carry_out == (wide_sel ? result[DATA_W-1] : result[HALF_W-1]))
                else $error("rotate right carry mismatch");
            p_shift_zero_flag_r9: assert (!(op_sel == 3'd4 || op_sel == 3'd5 || op_sel == 3'd7) ||
                count == '0 || zero_out == (result == '0))
                else $error("shift zero flag mismatch");
            p_zero_fill_big_count_r12: assert (!(op_sel == 3'd4 || op_sel == 3'd5) ||
                count < wid || result == '0)
                else $error("zero-fill shift beyond width not zero");
            p_sar_big_count_r12: assert (op_sel != 3'd7 || count < wid ||
                (result == (sgn ? msk : '0) && carry_out == sgn))
                else $error("arithmetic shift beyond width wrong");
        end
    end

endmodule

bind shift_rotate_unit rsu_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_rsu_checker (
    .operand    (operand),
    .count      (count),
    .op_sel     (op_sel),
    .wide_sel   (wide_sel),
    .carry_in   (carry_in),
    .sign_in    (sign_in),
    .zero_in    (zero_in),
    .parity_in  (parity_in),
    .result     (result),
    .carry_out  (carry_out),
    .sign_out   (sign_out),
    .zero_out   (zero_out),
    .parity_out (parity_out)
);

// File: tb/test_shift_rotate_unit.sv
module test_shift_rotate_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] operand = '0;
    logic [4:0]  count = '0;
    logic [2:0]  op_sel = '0;
    logic        wide_sel = 1'b0, carry_in = 1'b0, sign_in = 1'b0, zero_in = 1'b0, parity_in = 1'b0;
    logic [15:0] result;
    logic        carry_out, sign_out, zero_out, parity_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    shift_rotate_unit i_shift_rotate_unit (
        .operand(operand), .count(count), .op_sel(op_sel), .wide_sel(wide_sel),
        .carry_in(carry_in), .sign_in(sign_in), .zero_in(zero_in), .parity_in(parity_in),
        .result(result), .carry_out(carry_out), .sign_out(sign_out),
        .zero_out(zero_out), .parity_out(parity_out)
    );

    // Bundle layout: {result[15:0], carry, sign, zero, parity}
    function automatic logic [19:0] model(input logic [15:0] opd, input int cnt, input bit ci,
                                          input bit si, input bit zi, input bit pi,
                                          input int op, input bit wide);
        int w = wide ? 16 : 8;
        logic [15:0] mask = wide ? 16'hFFFF : 16'h00FF;
        logic [15:0] v = opd & mask;
        bit c = ci, s = si, z = zi, p = pi, t, sb;
        if (cnt == 0 || op == 6) return {v, c, s, z, p};
        for (int k = 0; k < cnt; k++) begin
            case (op)
                0: begin t = v[w-1]; v = ((v << 1) | {15'b0, t}) & mask; c = t; end
                1: begin t = v[0]; v = v >> 1; v[w-1] = t; c = t; end
                2: begin t = v[w-1]; v = ((v << 1) | {15'b0, c}) & mask; c = t; end
                3: begin t = v[0]; v = v >> 1; v[w-1] = c; c = t; end
                4: begin t = v[w-1]; v = (v << 1) & mask; c = t; end
                5: begin t = v[0]; v = v >> 1; c = t; end
                default: begin t = v[0]; sb = v[w-1]; v = v >> 1; v[w-1] = sb; c = t; end
            endcase
        end
        if (op >= 4) begin
            s = v[w-1];
            z = (v == 16'h0);
            p = ~^v[7:0];
        end
        return {v, c, s, z, p};
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            7: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic drive(input logic [15:0] opd, input int cnt, input bit ci, input bit si,
                         input bit zi, input bit pi, input int op, input bit wide);
        @(posedge clk);
        operand  = opd;
        count    = 5'(cnt);
        op_sel   = 3'(op);
        wide_sel = wide;
        carry_in = ci;
        sign_in  = si;
        zero_in  = zi;
        parity_in = pi;
        @(negedge clk);
    endtask

    task automatic compare(input logic [19:0] exp, input string tag);
        logic [19:0] act = {result, carry_out, sign_out, zero_out, parity_out};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got res=%h c=%b s=%b z=%b p=%b expected res=%h c=%b s=%b z=%b p=%b",
                     tag, act[19:4], act[3], act[2], act[1], act[0],
                     exp[19:4], exp[3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic directed(input logic [15:0] opd, input int cnt, input bit ci, input bit si,
                            input bit zi, input bit pi, input int op, input bit wide,
                            input logic [19:0] exp, input string tag);
        drive(opd, cnt, ci, si, zi, pi, op, wide);
        compare(exp, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state, count zero passthrough with all-zero inputs: R11
        compare(20'h0, "R11");

        directed(16'h0080, 1, 0, 0, 0, 0, 0, 0, {16'h0001, 4'b1000}, "R2");
        directed(16'h8001, 16, 0, 0, 0, 0, 0, 1, {16'h8001, 4'b1000}, "R2");
        directed(16'h0001, 1, 0, 1, 1, 1, 1, 1, {16'h8000, 4'b1111}, "R3 R10");
        directed(16'h0080, 1, 0, 0, 0, 0, 2, 0, {16'h0000, 4'b1000}, "R4");
        directed(16'h005A, 9, 1, 0, 0, 0, 2, 0, {16'h005A, 4'b1000}, "R4");
        directed(16'h0001, 1, 1, 0, 0, 0, 3, 0, {16'h0080, 4'b1000}, "R5");
        directed(16'h0000, 17, 1, 0, 0, 0, 3, 1, {16'h0000, 4'b1000}, "R5");
        directed(16'h0081, 1, 0, 1, 1, 1, 4, 0, {16'h0002, 4'b1000}, "R6 R9");
        directed(16'h8000, 1, 0, 0, 0, 0, 4, 1, {16'h0000, 4'b1011}, "R6 R9");
        directed(16'h00F0, 4, 1, 0, 0, 0, 5, 0, {16'h000F, 4'b0001}, "R7");
        directed(16'h4000, 3, 1, 0, 0, 0, 7, 1, {16'h0800, 4'b0001}, "R8");
        directed(16'h8001, 16, 0, 0, 0, 0, 5, 1, {16'h0000, 4'b1011}, "R12");
        directed(16'h8001, 17, 1, 0, 0, 0, 5, 1, {16'h0000, 4'b0011}, "R12");
        directed(16'h0080, 20, 0, 0, 0, 0, 7, 0, {16'h00FF, 4'b1101}, "R12 R8");
        directed(16'h1234, 5, 1, 0, 1, 0, 6, 1, {16'h1234, 4'b1010}, "R11 R1");
        directed(16'hABCD, 0, 0, 1, 0, 1, 0, 0, {16'h00CD, 4'b0101}, "R13 R11");

        void'($urandom(32'd20240611));
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] r_opd = 16'($urandom);
            int r_cnt  = int'($urandom_range(0, 31));
            int r_op   = int'($urandom_range(0, 7));
            bit r_wide = 1'($urandom_range(0, 1));
            bit r_ci   = 1'($urandom_range(0, 1));
            bit r_si   = 1'($urandom_range(0, 1));
            bit r_zi   = 1'($urandom_range(0, 1));
            bit r_pi   = 1'($urandom_range(0, 1));
            drive(r_opd, r_cnt, r_ci, r_si, r_zi, r_pi, r_op, r_wide);
            compare(model(r_opd, r_cnt, r_ci, r_si, r_zi, r_pi, r_op, r_wide),
                    r_wide ? tag_of(r_op) : {tag_of(r_op), " R13"});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule